// File: doc/BRIEF.md
# USB Control Endpoint Status and Handshake Selector

This block holds the control and status byte of a USB device's control endpoint (endpoint 0) and decides which handshake the serial engine gives for each IN or OUT token aimed at that endpoint. Firmware reads and writes the byte through an 8-bit port. Some bits are plain control bits that firmware loads directly. Others are flags that hardware sets and firmware clears by writing 1 to a separate service bit.

The USB side supplies single-cycle event strobes and an IN-FIFO-empty level. The block answers with a 2-bit response code for the direction of the current token. The code is combinational from the stored state, so the serial engine can sample it in the same cycle it presents the token direction.

Two states dominate the answer:
- Once a SETUP packet has arrived, every token is NAKed until firmware acknowledges the packet.
- Once firmware marks the data stage finished, every token is STALLed until the status stage completes and hardware clears the mark.

Top module: `ep0_ctl_status`

## Requirements
- R1: After reset every stored bit is 0, and `reg_rdata` reads 0x00.
- R2: Register layout, by bit position: 0 OUT-ready, 1 IN-ready, 2 stall-request, 3 stage-done, 4 protocol-fault, 5 early-end, 6 acknowledge-OUT strobe, 7 acknowledge-early-end strobe. Bits 6 and 7 always read 0.
- R3: OUT-ready is set by `ev_out_rx` or by `ev_setup`. A write with bit 6 = 1 clears it. A write with bit 6 = 0 leaves it unchanged.
- R4: IN-ready and stall-request are loaded from bits 1 and 2 on every write. `ev_in_tx` clears IN-ready, except in a cycle that also carries a write.
- R5: Stage-done is loaded from bit 3 on every write. `ev_status_done` clears it, except in a cycle that also carries a write.
- R6: Protocol-fault is set by `ev_proto_err` and cleared by a write with bit 4 = 1. Early-end is set by `ev_early_end` and cleared by a write with bit 7 = 1. Writing 0 to bit 7 or to bit 4 has no effect.
- R7: When a hardware set and a firmware clear of the same flag fall in the same cycle, the flag ends up set.
- R8: Response code encoding: 0 = data or ACK, 1 = zero-length data, 2 = NAK, 3 = STALL. The code is 3 whenever stall-request, stage-done or protocol-fault is 1.
- R9: When no stall condition holds, the code is 2 from the cycle after `ev_setup` until a write with bit 6 = 1 has taken effect.
- R10: With no stall and no pending SETUP, an IN token (`tok_in` = 1) gets one of three codes:
  - 2 when IN-ready is 0;
  - 1 when IN-ready is 1 and `in_fifo_empty` is 1;
  - 0 when IN-ready is 1 and the FIFO holds data.
- R11: With no stall and no pending SETUP, an OUT token (`tok_in` = 0) gets 0 when OUT-ready is 0 and 2 when OUT-ready is 1.
- R12: The reject sequence must work. The writes are 0x04, then 0x0C, then 0x4C, issued after a SETUP. The result is that OUT-ready is cleared, the pending SETUP is released, and the code is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Firmware write strobe |
| reg_wdata | input | 8 | Firmware write data |
| reg_rdata | output | 8 | Register read value |
| ev_setup | input | 1 | SETUP packet received |
| ev_out_rx | input | 1 | OUT data packet received |
| ev_in_tx | input | 1 | IN packet transmitted |
| ev_status_done | input | 1 | Status stage completed |
| ev_proto_err | input | 1 | Protocol error detected |
| ev_early_end | input | 1 | Control transfer ended before full length |
| in_fifo_empty | input | 1 | IN FIFO holds no data |
| tok_in | input | 1 | Current token direction, 1 = IN, 0 = OUT |
| resp_code | output | 2 | Handshake selection for the token |

## Verification
The assertions take three things for granted about the inputs.
- Every event is a one-cycle strobe.
- A write's effect is the only firmware action in its cycle.
- The clearing effects of `ev_in_tx` and `ev_status_done` are checked only in cycles without a write. A write in the same cycle loads those bits and overrides the clear.

The stimulus raises each strobe for exactly one cycle between falling edges and holds `reg_wr` low outside write cycles. It builds every reachable combination of stored bits from reset through events and writes, so no state is forced in that the interfaces cannot produce.

// File: rtl/ep0_pkg.sv
// Shared types and field positions for the control endpoint status block.
// Assumes an 8-bit firmware register; bit positions are fixed by the decode in ep0_csr_bank.
package ep0_pkg;
    localparam int REG_W  = 8;
    localparam int RESP_W = 2;

    // Field positions of the firmware register
    localparam int B_OUTRDY = 0;
    localparam int B_INRDY  = 1;
    localparam int B_STALL  = 2;
    localparam int B_DONE   = 3;
    localparam int B_FAULT  = 4;
    localparam int B_EARLY  = 5;
    localparam int B_ACKOUT = 6;
    localparam int B_ACKEND = 7;

    // Hardware-set flags held in the event-flag array
    localparam int F_OUTRDY = 0;
    localparam int F_FAULT  = 1;
    localparam int F_EARLY  = 2;
    localparam int F_SETUP  = 3;
    localparam int NFLAG    = 4;

    typedef enum logic [RESP_W-1:0] {
        RESP_DATA  = 2'd0,
        RESP_ZLP   = 2'd1,
        RESP_NAK   = 2'd2,
        RESP_STALL = 2'd3
    } resp_t;

    typedef struct packed {
        logic out_rdy;
        logic in_rdy;
        logic stall_req;
        logic stage_done;
        logic fault;
        logic early_end;
        logic setup_pend;
    } ep0_state_t;
endpackage

// File: rtl/ep0_evt_flag.sv
// Sticky flag: hardware sets it, firmware clears it.
// Assumes set and clear are single-cycle; a set in the same cycle as a clear wins.
module ep0_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold the flag, with set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/ep0_csr_bank.sv
// Stored state of the endpoint 0 register: hardware-set flags and firmware-loaded control bits.
// Assumes event inputs are one-cycle strobes; a firmware write overrides a hardware clear of loaded bits.
module ep0_csr_bank
    import ep0_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               ev_setup,
    input  logic               ev_out_rx,
    input  logic               ev_in_tx,
    input  logic               ev_status_done,
    input  logic               ev_proto_err,
    input  logic               ev_early_end,
    output ep0_state_t         st,
    output logic [REG_W-1:0]   rdata
);
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] flag_q;
    logic             in_rdy_q;
    logic             stall_q;
    logic             done_q;

    // Route events and firmware service bits to each sticky flag
    always_comb begin
        set_v           = '0;
        clr_v           = '0;
        set_v[F_OUTRDY] = ev_out_rx | ev_setup;
        clr_v[F_OUTRDY] = reg_wr & reg_wdata[B_ACKOUT];
        set_v[F_FAULT]  = ev_proto_err;
        clr_v[F_FAULT]  = reg_wr & reg_wdata[B_FAULT];
        set_v[F_EARLY]  = ev_early_end;
        clr_v[F_EARLY]  = reg_wr & reg_wdata[B_ACKEND];
        set_v[F_SETUP]  = ev_setup;
        clr_v[F_SETUP]  = reg_wr & reg_wdata[B_ACKOUT];
    end

    // One sticky cell per hardware-set flag
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        ep0_evt_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q     (flag_q[i])
        );
    end

    // Firmware-loaded bits; hardware may clear IN-ready and stage-done when no write is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_rdy_q <= 1'b0;
            stall_q  <= 1'b0;
            done_q   <= 1'b0;
        end else if (reg_wr) begin
            in_rdy_q <= reg_wdata[B_INRDY];
            stall_q  <= reg_wdata[B_STALL];
            done_q   <= reg_wdata[B_DONE];
        end else begin
            if (ev_in_tx)       in_rdy_q <= 1'b0;
            if (ev_status_done) done_q   <= 1'b0;
        end
    end

    // Collect state and build the read value; the strobe bits read as zero
    always_comb begin
        st.out_rdy    = flag_q[F_OUTRDY];
        st.in_rdy     = in_rdy_q;
        st.stall_req  = stall_q;
        st.stage_done = done_q;
        st.fault      = flag_q[F_FAULT];
        st.early_end  = flag_q[F_EARLY];
        st.setup_pend = flag_q[F_SETUP];

        rdata           = '0;
        rdata[B_OUTRDY] = st.out_rdy;
        rdata[B_INRDY]  = st.in_rdy;
        rdata[B_STALL]  = st.stall_req;
        rdata[B_DONE]   = st.stage_done;
        rdata[B_FAULT]  = st.fault;
        rdata[B_EARLY]  = st.early_end;
    end
endmodule

// File: rtl/ep0_hs_pick.sv
// Handshake selection for a token on endpoint 0.
// Priority: STALL, then NAK while a SETUP is pending, then the direction-specific answer.
// Assumes tok_in is valid whenever the serial engine samples the result.
module ep0_hs_pick
    import ep0_pkg::*;
(
    input  ep0_state_t         st,
    input  logic               tok_in,
    input  logic               in_fifo_empty,
    output logic [RESP_W-1:0]  resp_code
);
    resp_t resp;

    // Priority-ordered choice of the handshake
    always_comb begin
        if (st.stall_req || st.stage_done || st.fault)
            resp = RESP_STALL;
        else if (st.setup_pend)
            resp = RESP_NAK;
        else if (tok_in)
            resp = !st.in_rdy ? RESP_NAK : (in_fifo_empty ? RESP_ZLP : RESP_DATA);
        else
            resp = st.out_rdy ? RESP_NAK : RESP_DATA;
        resp_code = resp;
    end
endmodule

// File: rtl/ep0_ctl_status.sv
// Top of the endpoint 0 control and status block: register bank plus handshake selector.
// Assumes one firmware write per cycle at most and single-cycle USB event strobes.
module ep0_ctl_status
    import ep0_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               ev_setup,
    input  logic               ev_out_rx,
    input  logic               ev_in_tx,
    input  logic               ev_status_done,
    input  logic               ev_proto_err,
    input  logic               ev_early_end,
    input  logic               in_fifo_empty,
    input  logic               tok_in,
    output logic [RESP_W-1:0]  resp_code
);
    ep0_state_t st;

    ep0_csr_bank u_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .ev_setup       (ev_setup),
        .ev_out_rx      (ev_out_rx),
        .ev_in_tx       (ev_in_tx),
        .ev_status_done (ev_status_done),
        .ev_proto_err   (ev_proto_err),
        .ev_early_end   (ev_early_end),
        .st             (st),
        .rdata          (reg_rdata)
    );

    ep0_hs_pick u_pick (
        .st            (st),
        .tok_in        (tok_in),
        .in_fifo_empty (in_fifo_empty),
        .resp_code     (resp_code)
    );
endmodule

// File: rtl/ep0_ctl_status_chk.sv
// Assertion checker for ep0_ctl_status, relating port behaviour across cycles.
// Assumes strobes last one cycle; attached to every instance through bind.
module ep0_ctl_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       ev_setup,
    input logic       ev_out_rx,
    input logic       ev_in_tx,
    input logic       ev_status_done,
    input logic [1:0] resp_code
);
    // R8: any stall source forces the STALL code
    a_r8_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2] || reg_rdata[3] || reg_rdata[4]) |-> resp_code == 2'd3);

    // R3: a received OUT packet shows in bit 0 next cycle
    a_r3_out_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_out_rx |=> reg_rdata[0]);

    // R7: hardware set beats firmware clear of OUT-ready
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_out_rx && reg_wr && reg_wdata[6]) |=> reg_rdata[0]);

    // R9: after a SETUP the answer is NAK or STALL
    a_r9_setup_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_setup && !reg_wr) |=> (resp_code == 2'd2 || resp_code == 2'd3));

    // R4: a transmitted IN packet clears IN-ready when no write coincides
    a_r4_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in_tx && !reg_wr) |=> !reg_rdata[1]);

    // R5: status stage completion clears stage-done when no write coincides
    a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_status_done && !reg_wr) |=> !reg_rdata[3]);

    // R4: a write loads the stall-request bit
    a_r4_stall_load: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[2] == $past(reg_wdata[2]));
endmodule

bind ep0_ctl_status ep0_ctl_status_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .ev_setup       (ev_setup),
    .ev_out_rx      (ev_out_rx),
    .ev_in_tx       (ev_in_tx),
    .ev_status_done (ev_status_done),
    .resp_code      (resp_code)
);

// File: tb/sim_ep0_ctl_status.sv
// Self-checking bench: directed flag tests plus a sweep over every reachable stored state.
module sim_ep0_ctl_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ev_setup = 1'b0, ev_out_rx = 1'b0, ev_in_tx = 1'b0;
    logic       ev_status_done = 1'b0, ev_proto_err = 1'b0, ev_early_end = 1'b0;
    logic       in_fifo_empty = 1'b0, tok_in = 1'b0;
    logic [1:0] resp_code;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    ep0_ctl_status u0 (.*);

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk2(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus, launched and removed on falling edges
    task automatic cyc();
        @(negedge clk);
        reg_wr = 0; ev_setup = 0; ev_out_rx = 0; ev_in_tx = 0;
        ev_status_done = 0; ev_proto_err = 0; ev_early_end = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1; reg_wdata = d; cyc();
    endtask

    task automatic do_reset();
        rst_n = 0; cyc(); cyc(); rst_n = 1;
    endtask

    // Expected response from the requirement text (R8-R11)
    function automatic logic [1:0] exp_resp(input bit ss, input bit de, input bit fs, input bit sp,
                                            input bit ir, input bit orx, input bit ti, input bit fe);
        if (ss || de || fs) return 2'd3;
        if (sp) return 2'd2;
        if (ti) return !ir ? 2'd2 : (fe ? 2'd1 : 2'd0);
        return orx ? 2'd2 : 2'd0;
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        chk8("R1 reset value", reg_rdata, 8'h00);

        // R3: OUT packet sets bit 0, acknowledge strobe clears, zero write leaves it
        ev_out_rx = 1; cyc();
        chk8("R3 out set", reg_rdata, 8'h01);
        wr(8'h00);
        chk8("R3 write 0 to b6 no effect", reg_rdata, 8'h01);
        wr(8'h40);
        chk8("R3 ack clears", reg_rdata, 8'h00);

        // R7: set and clear in the same cycle
        ev_out_rx = 1; reg_wr = 1; reg_wdata = 8'h40; cyc();
        chk8("R7 set wins", reg_rdata, 8'h01);
        wr(8'h40);

        // R4: IN-ready load and hardware clear, and write priority over clear
        wr(8'h02);
        chk8("R4 in ready load", reg_rdata, 8'h02);
        ev_in_tx = 1; cyc();
        chk8("R4 in tx clears", reg_rdata, 8'h00);
        ev_in_tx = 1; reg_wr = 1; reg_wdata = 8'h02; cyc();
        chk8("R4 write beats clear", reg_rdata, 8'h02);

        // R5: stage-done and status completion
        wr(8'h08);
        chk8("R5 done load", reg_rdata, 8'h08);
        tok_in = 1; #1;
        chk2("R5/R8 done stalls", resp_code, 2'd3);
        ev_status_done = 1; cyc();
        chk8("R5 status clears", reg_rdata, 8'h00);

        // R6: protocol fault and early end
        ev_proto_err = 1; ev_early_end = 1; cyc();
        chk8("R6 hw sets", reg_rdata, 8'h30);
        wr(8'h00);
        chk8("R6 zero write no effect", reg_rdata, 8'h30);
        wr(8'h80);
        chk8("R6 b7 clears early end", reg_rdata, 8'h10);
        wr(8'h10);
        chk8("R6 b4 clears fault", reg_rdata, 8'h00);

        // R2: strobe bits read zero
        wr(8'hFF);
        chk8("R2 strobes read 0", reg_rdata, 8'h0E);
        wr(8'h00);

        // R12: reject sequence after SETUP
        ev_setup = 1; cyc();
        tok_in = 0; #1;
        chk2("R9 setup nak", resp_code, 2'd2);
        wr(8'h04); wr(8'h0C); wr(8'h4C);
        chk8("R12 reject state", reg_rdata, 8'h0C);
        chk2("R12 reject stall", resp_code, 2'd3);
        wr(8'h00);
        chk2("R12 setup released", resp_code, 2'd0);

        // R8-R11 sweep over every reachable stored state
        for (int c = 0; c < 64; c++) begin
            bit ss = c[0], de = c[1], fs = c[2], sp = c[3], ir = c[4], orx = c[5];
            do_reset();
            if (sp)  begin ev_setup = 1; cyc(); end
            if (orx) begin ev_out_rx = 1; cyc(); end
            if (fs)  begin ev_proto_err = 1; cyc(); end
            wr({4'b0, de, ss, ir, 1'b0});
            chk8("R2 sweep read", reg_rdata, {3'b0, fs, de, ss, ir, (orx | sp)});
            for (int k = 0; k < 4; k++) begin
                tok_in = k[0]; in_fifo_empty = k[1]; #1;
                chk2(tok_in ? "R10 sweep IN" : "R11 sweep OUT", resp_code,
                     exp_resp(ss, de, fs, sp, ir, orx | sp, k[0], k[1]));
            end
        end
        done = 1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule